// File: doc/BRIEF.md
# Reference Divider with Per-Loop Postscaler Taps

This block turns a fast reference clock into the comparison pulses of two phase-locked loops. A single programmable counter divides the reference by a 12-bit ratio, and a chain of three halving stages follows it. The chain offers four taps, at divide-by-1, 2, 4 and 8 of the counter rate. The main loop and the auxiliary loop each pick their own tap with a 2-bit select. The two select codes run in opposite directions. A third output carries the raw counter terminal count, for test observation.

The counter is controlled by a two-state machine. In `ST_STOPPED` the counter holds its reload value and the halving stages are held clear. The transition to `ST_RUN` happens on the first clock edge at which either loop enable is high. In `ST_RUN` the counter counts down and reloads at zero. The transition back to `ST_STOPPED` happens on any edge at which both enables are low. A ratio written while the counter runs is picked up at the next reload, so the current period always completes with the old value. Every output is a registered pulse one reference cycle wide.

Top module: `refclk_postdiv`

## Requirements
- R1: While reset is held, and after reset with both enables low, all three outputs are 0.
- R2: With a ratio R from 4 to 4095 and the block running, `div_test_o` pulses high for exactly one cycle every R cycles. The first pulse appears after the R-th rising edge that follows the first edge sampling an enable high.
- R3: Ratio values 0 to 3 behave exactly like a ratio of 4.
- R4: A ratio change made while running takes effect at the next terminal count. The period in progress ends with the old ratio, and the following period uses the new one.
- R5: `main_sel_i` picks the main tap with 0 for divide-by-1, 1 for divide-by-2, 2 for divide-by-4 and 3 for divide-by-8. The main pulse period is R·2^sel. The first main pulse follows edge R·2^sel after the start.
- R6: `aux_sel_i` picks the auxiliary tap in reverse order: 3 for divide-by-1, 2 for divide-by-2, 1 for divide-by-4 and 0 for divide-by-8. The period and first-pulse position follow the same rule as R5, with the divisor given by this mapping.
- R7: When both enables are low, the chain stops, no output pulses, and the next start begins again from the initial counter and stage state.
- R8: A low `main_en_i` keeps `main_ref_o` at 0, and a low `aux_en_i` keeps `aux_ref_o` at 0, while the other loop continues to run.
- R9: Every main or auxiliary pulse coincides with a `div_test_o` pulse, because all taps are phase aligned to the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_i | input | 12 | Counter division ratio, clamped up to 4 |
| main_sel_i | input | 2 | Main loop tap select |
| aux_sel_i | input | 2 | Auxiliary loop tap select (reversed order) |
| main_en_i | input | 1 | Main loop enable |
| aux_en_i | input | 1 | Auxiliary loop enable |
| main_ref_o | output | 1 | Main phase detector reference pulse |
| aux_ref_o | output | 1 | Auxiliary phase detector reference pulse |
| div_test_o | output | 1 | Counter terminal count pulse for test |

## Verification
The assertions take no promise from the inputs beyond reset. Enables, selects and the ratio may change on any cycle. The pulse-spacing property holds only because the clamp keeps the counter period at least four cycles, and the alignment properties rest on every tap being derived from the same terminal count. The stimulus changes selects only while both enables are low. The single exception is the ratio update check, which writes a new ratio just after a terminal count. This keeps every measured first-pulse position and interval tied to a known start from `ST_STOPPED`.

// File: rtl/refclk_postdiv_pkg.sv
package refclk_postdiv_pkg;

    localparam int RATIO_W_DEF   = 12;
    localparam int MIN_RATIO_DEF = 4;
    localparam int STAGES_DEF    = 3;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUN     = 1'b1
    } div_state_t;

endpackage

// File: rtl/refclk_ratio_counter.sv
module refclk_ratio_counter
    import refclk_postdiv_pkg::*;
#(
    parameter int RATIO_W   = RATIO_W_DEF,
    parameter int MIN_RATIO = MIN_RATIO_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tc_o,
    output logic               stopped_o
);

    localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

    div_state_t         state_q, state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] eff_ratio;
    logic [RATIO_W-1:0] load_val;

    // Clamp short ratios so the period never drops below MIN_RATIO cycles
    assign eff_ratio = (ratio_i < MIN_R) ? MIN_R : ratio_i;
    assign load_val  = eff_ratio - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_i)  state_d = ST_RUN;
            ST_RUN:     if (!run_i) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    // Down counter; the ratio input is sampled only at a reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_STOPPED: cnt_q <= load_val;
                ST_RUN:     cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
                default:    cnt_q <= load_val;
            endcase
        end
    end

    assign tc_o      = (state_q == ST_RUN) && (cnt_q == '0);
    assign stopped_o = (state_q == ST_STOPPED);

endmodule

// File: rtl/refclk_postscaler.sv
module refclk_postscaler #(
    parameter int STAGES = refclk_postdiv_pkg::STAGES_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            tc_i,
    output logic [STAGES:0] taps_o
);

    logic [STAGES-1:0] stage_q;
    logic [STAGES:0]   carry;

    assign carry[0] = tc_i;

    // Each tap fires when every lower halving stage is at its top state
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_carry
            assign carry[g+1] = carry[g] & stage_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            stage_q <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                if (carry[k]) stage_q[k] <= ~stage_q[k];
            end
        end
    end

    assign taps_o = carry;

endmodule

// File: rtl/refclk_tap_mux.sv
module refclk_tap_mux #(
    parameter int STAGES   = refclk_postdiv_pkg::STAGES_DEF,
    parameter int SEL_W    = 2,
    parameter bit REVERSED = 1'b0
) (
    input  logic [STAGES:0]  taps_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tap_o
);

    logic [SEL_W-1:0] idx;

    generate
        if (REVERSED) begin : g_rev
            assign idx = SEL_W'(STAGES) - sel_i;
        end else begin : g_fwd
            assign idx = sel_i;
        end
    endgenerate

    assign tap_o = taps_i[idx];

endmodule

// File: rtl/refclk_postdiv.sv
module refclk_postdiv
    import refclk_postdiv_pkg::*;
#(
    parameter int RATIO_W   = RATIO_W_DEF,
    parameter int MIN_RATIO = MIN_RATIO_DEF,
    parameter int STAGES    = STAGES_DEF,
    parameter int SEL_W     = $clog2(STAGES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [SEL_W-1:0]   main_sel_i,
    input  logic [SEL_W-1:0]   aux_sel_i,
    input  logic               main_en_i,
    input  logic               aux_en_i,
    output logic               main_ref_o,
    output logic               aux_ref_o,
    output logic               div_test_o
);

    logic            run;
    logic            tc;
    logic            stopped;
    logic [STAGES:0] taps;
    logic            main_tap;
    logic            aux_tap;

    assign run = main_en_i | aux_en_i;

    refclk_ratio_counter #(
        .RATIO_W   (RATIO_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .ratio_i   (ratio_i),
        .tc_o      (tc),
        .stopped_o (stopped)
    );

    refclk_postscaler #(
        .STAGES (STAGES)
    ) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (stopped),
        .tc_i    (tc),
        .taps_o  (taps)
    );

    refclk_tap_mux #(
        .STAGES   (STAGES),
        .SEL_W    (SEL_W),
        .REVERSED (1'b0)
    ) u_main_mux (
        .taps_i (taps),
        .sel_i  (main_sel_i),
        .tap_o  (main_tap)
    );

    refclk_tap_mux #(
        .STAGES   (STAGES),
        .SEL_W    (SEL_W),
        .REVERSED (1'b1)
    ) u_aux_mux (
        .taps_i (taps),
        .sel_i  (aux_sel_i),
        .tap_o  (aux_tap)
    );

    // Output process: registered single-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_ref_o <= 1'b0;
            aux_ref_o  <= 1'b0;
            div_test_o <= 1'b0;
        end else begin
            main_ref_o <= main_en_i & main_tap;
            aux_ref_o  <= aux_en_i & aux_tap;
            div_test_o <= run & taps[0];
        end
    end

endmodule

// File: rtl/refclk_postdiv_chk.sv
module refclk_postdiv_chk (
    input logic clk,
    input logic rst_n,
    input logic main_en_i,
    input logic aux_en_i,
    input logic main_ref_o,
    input logic aux_ref_o,
    input logic div_test_o
);

    assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_test_o |=> !div_test_o ##1 !div_test_o ##1 !div_test_o);

    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en_i && !aux_en_i) |=> (!div_test_o && !main_ref_o && !aux_ref_o));

    assert_main_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en_i |=> !main_ref_o);

    assert_aux_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_en_i |=> !aux_ref_o);

    assert_main_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        main_ref_o |-> div_test_o);

    assert_aux_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        aux_ref_o |-> div_test_o);

endmodule

bind refclk_postdiv refclk_postdiv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_en_i  (main_en_i),
    .aux_en_i   (aux_en_i),
    .main_ref_o (main_ref_o),
    .aux_ref_o  (aux_ref_o),
    .div_test_o (div_test_o)
);

// File: tb/refclk_postdiv_tb.sv
`timescale 1ns/1ps
module refclk_postdiv_tb;

    localparam real CYC = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ratio_i = '0;
    logic [1:0]  main_sel_i = '0;
    logic [1:0]  aux_sel_i = '0;
    logic        main_en_i = 1'b0;
    logic        aux_en_i = 1'b0;
    logic        main_ref_o, aux_ref_o, div_test_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CYC/2) clk = ~clk;

    refclk_postdiv u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_i    (ratio_i),
        .main_sel_i (main_sel_i),
        .aux_sel_i  (aux_sel_i),
        .main_en_i  (main_en_i),
        .aux_en_i   (aux_en_i),
        .main_ref_o (main_ref_o),
        .aux_ref_o  (aux_ref_o),
        .div_test_o (div_test_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <200000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic stop_all();
        @(negedge clk);
        main_en_i = 1'b0;
        aux_en_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Start from stopped, count edges from the first enabled edge (index 1)
    task automatic run_cfg(input int ratio, input int sm, input int sa);
        int r, pm, pa, n;
        int m_first, m_second, m_cnt, a_first, a_second, a_cnt, t_first, t_cnt;
        stop_all();
        r  = (ratio < 4) ? 4 : ratio;   // R3 clamp
        pm = r << sm;                   // R5 main tap
        pa = r << (3 - sa);             // R6 reversed aux tap
        n  = 2 * ((pm > pa) ? pm : pa) + 2;
        m_first = 0; m_second = 0; m_cnt = 0;
        a_first = 0; a_second = 0; a_cnt = 0;
        t_first = 0; t_cnt = 0;
        ratio_i    = 12'(ratio);
        main_sel_i = 2'(sm);
        aux_sel_i  = 2'(sa);
        main_en_i  = 1'b1;
        aux_en_i   = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            #1;
            if (main_ref_o) begin
                m_cnt++;
                if (m_first == 0) m_first = i; else if (m_second == 0) m_second = i;
            end
            if (aux_ref_o) begin
                a_cnt++;
                if (a_first == 0) a_first = i; else if (a_second == 0) a_second = i;
            end
            if (div_test_o) begin
                t_cnt++;
                if (t_first == 0) t_first = i;
            end
        end
        check(t_first, r + 1, $sformatf("R2/R3 first test pulse ratio=%0d", ratio));
        check(t_cnt, (n - 1) / r, $sformatf("R2 test pulse count ratio=%0d", ratio));
        check(m_first, pm + 1, $sformatf("R5 main first ratio=%0d sel=%0d", ratio, sm));
        check(m_second - m_first, pm, $sformatf("R5 main period ratio=%0d sel=%0d", ratio, sm));
        check(m_cnt, (n - 1) / pm, $sformatf("R5 main count ratio=%0d sel=%0d", ratio, sm));
        check(a_first, pa + 1, $sformatf("R6 aux first ratio=%0d sel=%0d", ratio, sa));
        check(a_second - a_first, pa, $sformatf("R6 aux period ratio=%0d sel=%0d", ratio, sa));
        check(a_cnt, (n - 1) / pa, $sformatf("R6 aux count ratio=%0d sel=%0d", ratio, sa));
    endtask

    initial begin
        int ratios[6] = '{0, 3, 4, 5, 6, 11};
        int hits, p1, p2, p3, cnt, mhits, ahits;

        // R1: reset state and idle after reset
        repeat (3) @(negedge clk);
        check(main_ref_o | aux_ref_o | div_test_o, 0, "R1 outputs during reset");
        rst_n = 1'b1;
        ratio_i = 12'd5;
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            hits += main_ref_o + aux_ref_o + div_test_o;
        end
        check(hits, 0, "R1/R7 idle after reset");

        // R2 R3 R5 R6 R9 sweep across ratios and selects
        foreach (ratios[j]) begin
            for (int s = 0; s < 4; s++) run_cfg(ratios[j], s, s);
        end
        run_cfg(4095, 0, 3);

        // R7: stopped chain produces nothing
        stop_all();
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            hits += main_ref_o + aux_ref_o + div_test_o;
        end
        check(hits, 0, "R7 no pulses while stopped");

        // R4: ratio change lands at the next terminal count
        stop_all();
        ratio_i = 12'd5; main_sel_i = 2'd0; aux_sel_i = 2'd3;
        main_en_i = 1'b1; aux_en_i = 1'b1;
        p1 = 0; p2 = 0; p3 = 0; cnt = 0;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk); #1;
            if (div_test_o) begin
                cnt++;
                if (cnt == 1) begin p1 = i; ratio_i = 12'd9; end
                else if (cnt == 2) p2 = i;
                else if (cnt == 3) p3 = i;
            end
        end
        check(p1, 6, "R4 first pulse with old ratio");
        check(p2 - p1, 5, "R4 period in progress keeps old ratio");
        check(p3 - p2, 9, "R4 next period uses new ratio");

        // R8: one loop disabled, the other still running
        stop_all();
        ratio_i = 12'd4; main_sel_i = 2'd0; aux_sel_i = 2'd3;
        main_en_i = 1'b0; aux_en_i = 1'b1;
        mhits = 0; ahits = 0;
        for (int i = 1; i <= 41; i++) begin
            @(posedge clk); #1;
            mhits += main_ref_o; ahits += aux_ref_o;
        end
        check(mhits, 0, "R8 main held low when disabled");
        check(ahits, 10, "R8 aux keeps running");
        stop_all();
        main_en_i = 1'b1; aux_en_i = 1'b0;
        mhits = 0; ahits = 0;
        for (int i = 1; i <= 41; i++) begin
            @(posedge clk); #1;
            mhits += main_ref_o; ahits += aux_ref_o;
        end
        check(ahits, 0, "R8 aux held low when disabled");
        check(mhits, 10, "R8 main keeps running");

        // R9: main and aux pulses coincide with the test pulse at divide-by-8
        stop_all();
        ratio_i = 12'd4; main_sel_i = 2'd3; aux_sel_i = 2'd0;
        main_en_i = 1'b1; aux_en_i = 1'b1;
        hits = 0; cnt = 0;
        for (int i = 1; i <= 100; i++) begin
            @(posedge clk); #1;
            if (main_ref_o && aux_ref_o && div_test_o) hits++;
            if (main_ref_o != aux_ref_o) cnt++;
        end
        check(hits, 3, "R9 aligned pulses at divide-by-8");
        check(cnt, 0, "R9 main and aux taps in phase");

        stop_all();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule